// File: doc/BRIEF.md
# Multiplexed-Address DRAM Sequencer

This block sits between a host that issues single-word read and write requests and an asynchronous DRAM whose row and column addresses share one address bus. For each request it produces the active-low row strobe, column strobe, write enable and output enable, and it places the row half or the column half of the host address on the shared bus at the right moment. Read data is captured from the DRAM data pins and handed back to the host as a one-cycle response pulse.

The sequencer uses an open-page policy. After an access the row is left open. A later request to the same row goes straight to a column cycle. A request to any other row first closes the open row, waits out the precharge time and then opens the new row. A free-running interval timer raises a refresh request. That request is served as soon as the access in flight has finished. It is a row-only cycle, with the column strobe held high, on an internal row counter that steps once per refresh. Precharge, row-to-column delay, column strobe width, refresh row strobe width and the refresh interval are all parameters counted in controller clocks.

For deployment, choose `REF_INTERVAL` so that 2^`ADDR_W` refreshes fit inside the retention window of the array, which is about 8 ms.

Top module: `dram_seq_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every strobe output (`dramRasN`, `dramCasN`, `dramWeN`, `dramOeN`) is high, `rspValid` is low and `reqReady` is high.
- R2: On a host access, when `dramCasN` falls, `dramRasN` is already low. The address bus carried the row half `reqAddr[2*ADDR_W-1:ADDR_W]` when `dramRasN` fell, and it carries the column half `reqAddr[ADDR_W-1:0]` when `dramCasN` falls.
- R3: While `dramCasN` is low, a write holds `dramWeN` low, holds `dramOeN` high and drives the request data on `dramDqOut`. A read holds `dramOeN` low and `dramWeN` high. `dramWeN` and `dramOeN` are never low together.
- R4: A read returns `dramDqIn` as it stood in the last cycle of its column strobe. It is returned on `rspRdata` with `rspValid` high for exactly one cycle, the cycle after that last cycle. A write produces no `rspValid`.
- R5: `dramRasN` stays high for at least `T_RP` cycles before every falling edge.
- R6: `dramCasN` falls no sooner than `T_RCD` cycles after `dramRasN` fell.
- R7: `dramCasN` stays low for at least `T_CAS` cycles on every column access.
- R8: A request to the row that is currently open, made while no refresh is pending, gets a column cycle without `dramRasN` rising in between.
- R9: A request to a different row raises `dramRasN`, completes precharge (R5) and then strobes the new row. The data read back belongs to the new row.
- R10: Every `REF_INTERVAL` cycles a refresh becomes pending. A refresh is a `dramRasN` low period of `T_RAS` cycles with `dramCasN` high throughout. Successive refreshes present row addresses 0, 1, 2 and so on, modulo 2^`ADDR_W`. The gap between refreshes never exceeds the interval plus the length of one access.
- R11: An accepted access always completes before a pending refresh starts. `reqReady` stays low from the moment a refresh is pending until that refresh has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Request accepted this cycle when both are high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 2*ADDR_W | Word address, row in upper half, column in lower half |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | One-cycle read response strobe |
| rspRdata | output | DATA_W | Read data |
| dramAddr | output | ADDR_W | Shared row/column address bus |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramDqOut | output | DATA_W | Data driven to the array on writes |
| dramDqIn | input | DATA_W | Data returned by the array on reads |

## Verification
The collision of interest is the refresh timer expiring while a host access is in flight or while a page is open and the next request is already waiting. The bench keeps a dense stream of randomly mixed reads and writes running across many refresh intervals over a few rows, so that expiry lands in every phase of the sequence. A pin-level model judges each collision. It checks that every refresh row-only cycle came with `reqReady` low, that the refresh rows ascend without gaps and that the spacing between refreshes stays within bound. Every read still returns the word last written, and the precharge, row-to-column and column-width timings hold across the refresh boundary.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    ADDR_ROW,
    ADDR_COL,
    ADDR_REF
  } addrSel_e;

  typedef enum logic [2:0] {
    ST_CLOSED,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_OPEN,
    ST_REF
  } seqState_e;

  // Strobes from the sequencer to the datapath, one set per cycle.
  typedef struct packed {
    logic     rasLow;
    logic     casLow;
    logic     weLow;
    logic     oeLow;
    addrSel_e addrSel;
    logic     accept;
    logic     rowLoad;
    logic     capture;
    logic     refStep;
  } ctlStrobes_t;

endpackage

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int T_RP         = 3,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RAS        = 4,
  parameter int REF_INTERVAL = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        rowHit,
  output logic        reqReady,
  output ctlStrobes_t ctl
);

  localparam int MAX_A = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int MAX_B = (T_CAS > T_RAS) ? T_CAS : T_RAS;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam int REF_W = $clog2(REF_INTERVAL + 1);

  seqState_e          state, stateNext;
  logic [CNT_W-1:0]   waitCnt, waitLoad;
  logic               loadCnt;
  logic               hasReq, isWrite, refPending;
  logic [REF_W-1:0]   refTimer;
  logic               waitDone, accept;

  assign waitDone = (waitCnt == '0);
  assign reqReady = !refPending && (state == ST_CLOSED || state == ST_OPEN);
  assign accept   = reqValid && reqReady;

  always_comb begin
    stateNext = state;
    loadCnt   = 1'b0;
    waitLoad  = '0;
    unique case (state)
      ST_CLOSED: begin
        if (accept) begin
          stateNext = ST_ACT; loadCnt = 1'b1; waitLoad = CNT_W'(T_RCD - 1);
        end else if (refPending) begin
          stateNext = ST_REF; loadCnt = 1'b1; waitLoad = CNT_W'(T_RAS - 1);
        end
      end
      ST_OPEN: begin
        if (accept && rowHit) begin
          stateNext = ST_COL; loadCnt = 1'b1; waitLoad = CNT_W'(T_CAS - 1);
        end else if (accept || refPending) begin
          stateNext = ST_PRE; loadCnt = 1'b1; waitLoad = CNT_W'(T_RP - 1);
        end
      end
      ST_PRE: begin
        if (waitDone) begin
          if (hasReq) begin
            stateNext = ST_ACT; loadCnt = 1'b1; waitLoad = CNT_W'(T_RCD - 1);
          end else if (refPending) begin
            stateNext = ST_REF; loadCnt = 1'b1; waitLoad = CNT_W'(T_RAS - 1);
          end else begin
            stateNext = ST_CLOSED;
          end
        end
      end
      ST_ACT: begin
        if (waitDone) begin
          stateNext = ST_COL; loadCnt = 1'b1; waitLoad = CNT_W'(T_CAS - 1);
        end
      end
      ST_COL: begin
        if (waitDone) stateNext = ST_OPEN;
      end
      ST_REF: begin
        if (waitDone) begin
          stateNext = ST_PRE; loadCnt = 1'b1; waitLoad = CNT_W'(T_RP - 1);
        end
      end
      default: stateNext = ST_CLOSED;
    endcase
  end

  always_comb begin
    ctl.rasLow  = (state == ST_ACT) || (state == ST_COL) ||
                  (state == ST_OPEN) || (state == ST_REF);
    ctl.casLow  = (state == ST_COL);
    ctl.weLow   = (state == ST_COL) && isWrite;
    ctl.oeLow   = (state == ST_COL) && !isWrite;
    ctl.addrSel = (state == ST_REF) ? ADDR_REF :
                  (state == ST_COL) ? ADDR_COL : ADDR_ROW;
    ctl.accept  = accept;
    ctl.rowLoad = (state == ST_ACT);
    ctl.capture = (state == ST_COL) && waitDone && !isWrite;
    ctl.refStep = (state == ST_REF) && waitDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_CLOSED;
      waitCnt    <= '0;
      hasReq     <= 1'b0;
      isWrite    <= 1'b0;
      refPending <= 1'b0;
      refTimer   <= REF_W'(REF_INTERVAL - 1);
    end else begin
      state <= stateNext;
      if (loadCnt)       waitCnt <= waitLoad;
      else if (!waitDone) waitCnt <= waitCnt - 1'b1;

      if (accept) isWrite <= reqWrite;
      if (accept && state == ST_OPEN && !rowHit) hasReq <= 1'b1;
      else if (stateNext == ST_ACT)              hasReq <= 1'b0;

      if (state != ST_REF && stateNext == ST_REF) refPending <= 1'b0;
      if (refTimer == '0) begin
        refTimer   <= REF_W'(REF_INTERVAL - 1);
        refPending <= 1'b1;
      end else begin
        refTimer <= refTimer - 1'b1;
      end
    end
  end

  AST_REF_HELD: assert property (@(posedge clk) disable iff (!rstN)
    refPending |=> (refPending || state == ST_REF)); // R11

  AST_HIT_SKIPS_ROW: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OPEN && accept && rowHit) |=> (state == ST_COL)); // R8

  AST_REF_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACT) |=> (state != ST_REF)); // R11

endmodule

// File: rtl/dram_seq_path.sv
module dram_seq_path
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  parameter int T_RP   = 3,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         ctl,
  input  logic [2*ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W-1:0]   dramDqIn,
  output logic                rowHit,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspRdata,
  output logic [ADDR_W-1:0]   dramAddr,
  output logic                dramRasN,
  output logic                dramCasN,
  output logic                dramWeN,
  output logic                dramOeN,
  output logic [DATA_W-1:0]   dramDqOut
);

  localparam int CHK_A   = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int CHK_MAX = (CHK_A > T_CAS) ? CHK_A : T_CAS;
  localparam int CHK_W   = $clog2(CHK_MAX + 2);

  logic [ADDR_W-1:0] rowQ, colQ, openRow, refRow, addrNext;
  logic [DATA_W-1:0] wdataQ;
  logic              capQ;

  assign rowHit    = (reqAddr[2*ADDR_W-1:ADDR_W] == openRow);
  assign dramDqOut = wdataQ;

  always_comb begin
    unique case (ctl.addrSel)
      ADDR_COL: addrNext = colQ;
      ADDR_REF: addrNext = refRow;
      default:  addrNext = rowQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ     <= '0;
      colQ     <= '0;
      wdataQ   <= '0;
      openRow  <= '0;
      refRow   <= '0;
      capQ     <= 1'b0;
      rspValid <= 1'b0;
      rspRdata <= '0;
      dramAddr <= '0;
      dramRasN <= 1'b1;
      dramCasN <= 1'b1;
      dramWeN  <= 1'b1;
      dramOeN  <= 1'b1;
    end else begin
      if (ctl.accept) begin
        rowQ   <= reqAddr[2*ADDR_W-1:ADDR_W];
        colQ   <= reqAddr[ADDR_W-1:0];
        wdataQ <= reqWdata;
      end
      if (ctl.rowLoad) openRow <= rowQ;
      if (ctl.refStep) refRow  <= refRow + 1'b1;
      capQ     <= ctl.capture;
      rspValid <= capQ;
      if (capQ) rspRdata <= dramDqIn;
      dramAddr <= addrNext;
      dramRasN <= !ctl.rasLow;
      dramCasN <= !ctl.casLow;
      dramWeN  <= !ctl.weLow;
      dramOeN  <= !ctl.oeLow;
    end
  end

  // Pin-level run counters used only by the timing assertions below.
  logic [CHK_W-1:0] rasHighRun, rasLowRun, casLowRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasHighRun <= CHK_W'(CHK_MAX);
      rasLowRun  <= '0;
      casLowRun  <= '0;
    end else begin
      if (dramRasN) begin
        rasLowRun <= '0;
        if (rasHighRun != CHK_W'(CHK_MAX)) rasHighRun <= rasHighRun + 1'b1;
      end else begin
        rasHighRun <= '0;
        if (rasLowRun != CHK_W'(CHK_MAX)) rasLowRun <= rasLowRun + 1'b1;
      end
      if (dramCasN) casLowRun <= '0;
      else if (casLowRun != CHK_W'(CHK_MAX)) casLowRun <= casLowRun + 1'b1;
    end
  end

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rstN)
    !dramCasN |-> !dramRasN); // R2

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!dramWeN && !dramOeN)); // R3

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R4

  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |-> (rasHighRun >= CHK_W'(T_RP))); // R5

  AST_RCD_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramCasN) |-> (rasLowRun >= CHK_W'(T_RCD))); // R6

  AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dramCasN) |-> (casLowRun >= CHK_W'(T_CAS))); // R7

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int DATA_W       = 16,
  parameter int T_RP         = 3,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RAS        = 4,
  parameter int REF_INTERVAL = 200
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [2*ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspRdata,
  output logic [ADDR_W-1:0]   dramAddr,
  output logic                dramRasN,
  output logic                dramCasN,
  output logic                dramWeN,
  output logic                dramOeN,
  output logic [DATA_W-1:0]   dramDqOut,
  input  logic [DATA_W-1:0]   dramDqIn
);

  ctlStrobes_t ctl;
  logic        rowHit;

  dram_seq_fsm #(
    .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS),
    .REF_INTERVAL(REF_INTERVAL)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .rowHit(rowHit), .reqReady(reqReady), .ctl(ctl)
  );

  dram_seq_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS)
  ) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .dramDqIn(dramDqIn), .rowHit(rowHit), .rspValid(rspValid), .rspRdata(rspRdata),
    .dramAddr(dramAddr), .dramRasN(dramRasN), .dramCasN(dramCasN),
    .dramWeN(dramWeN), .dramOeN(dramOeN), .dramDqOut(dramDqOut)
  );

endmodule

// File: tb/dram_seq_ctrl_test.sv
module dram_seq_ctrl_test;

  localparam int AW = 14;
  localparam int DW = 16;
  localparam int T_RP = 3, T_RCD = 2, T_CAS = 2, T_RAS = 4, REF_INTERVAL = 200;
  localparam int SLACK = 2 * T_RP + T_RCD + T_CAS + T_RAS + 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, reqValid, reqReady, reqWrite, rspValid;
  logic [2*AW-1:0] reqAddr;
  logic [DW-1:0]   reqWdata, rspRdata, dramDqOut, dramDqIn;
  logic [AW-1:0]   dramAddr;
  logic dramRasN, dramCasN, dramWeN, dramOeN;

  dram_seq_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS),
                  .T_RAS(T_RAS), .REF_INTERVAL(REF_INTERVAL)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid), .rspRdata(rspRdata),
    .dramAddr(dramAddr), .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
    .dramOeN(dramOeN), .dramDqOut(dramDqOut), .dramDqIn(dramDqIn));

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] patt(logic [2*AW-1:0] a);
    return a[15:0] ^ {2'b00, a[2*AW-1:AW]} ^ 16'hA55A;
  endfunction

  // Bench view of the issued request and expected memory contents.
  logic [AW-1:0] issRow, issCol;
  logic [DW-1:0] issData;
  bit            issWr;
  logic [DW-1:0] expMem [int];
  logic [DW-1:0] modelMem [int];

  // Pin-level behavioural DRAM model with timing and refresh monitors.
  bit prevRas, prevCas, casSeen, readySeen;
  int rasHighRun, rasLowRun, casLowRun, cyc, lastRef;
  int refCount = 0, actCount = 0, hitCount = 0, rspCount = 0;
  logic [AW-1:0] curRow, expRef;

  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      prevRas = 1; prevCas = 1; rasHighRun = 100; rasLowRun = 0; casLowRun = 0;
      casSeen = 0; readySeen = 0; expRef = '0; lastRef = cyc; dramDqIn <= '0;
    end else begin
      if (rspValid) rspCount++;
      if (prevRas && !dramRasN) begin
        check(rasHighRun >= T_RP, "R5", "precharge cycles", rasHighRun, T_RP);
        curRow = dramAddr; casSeen = 0; readySeen = 0;
      end
      if (!dramRasN && reqReady && !casSeen) readySeen = 1;
      if (prevCas && !dramCasN) begin
        check(!dramRasN, "R2", "ras low at cas fall", dramRasN, 0);
        check(rasLowRun >= T_RCD, "R6", "ras-to-cas cycles", rasLowRun, T_RCD);
        check(curRow == issRow, "R2", "row address", curRow, issRow);
        check(dramAddr == issCol, "R2", "column address", dramAddr, issCol);
        if (issWr)
          check(!dramWeN && dramOeN && dramDqOut == issData, "R3", "write strobes/data",
                {dramWeN, dramOeN, dramDqOut}, {2'b01, issData});
        else
          check(dramWeN && !dramOeN, "R3", "read strobes", {dramWeN, dramOeN}, 2'b10);
        if (casSeen) hitCount++; else actCount++;
        casSeen = 1;
      end
      if (!prevCas && dramCasN)
        check(casLowRun >= T_CAS, "R7", "cas width", casLowRun, T_CAS);
      if (!prevRas && dramRasN && !casSeen) begin
        check(curRow == expRef, "R10", "refresh row", curRow, expRef);
        check(rasLowRun == T_RAS, "R10", "refresh ras width", rasLowRun, T_RAS);
        check(cyc - lastRef <= REF_INTERVAL + SLACK, "R10", "refresh gap",
              cyc - lastRef, REF_INTERVAL + SLACK);
        check(!readySeen, "R11", "ready low during refresh", readySeen, 0);
        expRef = expRef + 1'b1; refCount++; lastRef = cyc;
      end
      if (!dramCasN && !dramWeN) modelMem[int'({curRow, dramAddr})] = dramDqOut;
      if (!dramCasN && !dramOeN)
        dramDqIn <= modelMem.exists(int'({curRow, dramAddr})) ?
                    modelMem[int'({curRow, dramAddr})] : patt({curRow, dramAddr});
      else
        dramDqIn <= '0;
      if (dramRasN) begin rasHighRun++; rasLowRun = 0; end
      else begin rasLowRun++; rasHighRun = 0; end
      if (dramCasN) casLowRun = 0; else casLowRun++;
      prevRas = dramRasN; prevCas = dramCasN;
    end
  end

  task automatic doOp(bit wr, logic [2*AW-1:0] a, logic [DW-1:0] d);
    int n;
    int rsp0;
    issRow = a[2*AW-1:AW]; issCol = a[AW-1:0]; issWr = wr; issData = d;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    n = 0;
    while (!reqReady && n < 300) begin @(negedge clk); n++; end
    @(negedge clk);
    reqValid = 0;
    if (wr) begin
      expMem[int'(a)] = d;
      rsp0 = rspCount;
      repeat (T_RCD + T_CAS + T_RP + 4) @(negedge clk);
      check(rspCount == rsp0, "R4", "no response to write", rspCount - rsp0, 0);
    end else begin
      n = 0;
      while (!rspValid && n < 60) begin @(negedge clk); n++; end
      check(rspValid, "R4", "read response arrived", rspValid, 1);
      check(rspRdata == (expMem.exists(int'(a)) ? expMem[int'(a)] : patt(a)), "R4",
            "read data", rspRdata, expMem.exists(int'(a)) ? expMem[int'(a)] : patt(a));
      @(negedge clk);
      check(!rspValid, "R4", "single-cycle response", rspValid, 0);
    end
  endtask

  initial begin
    int unsigned seed;
    int a0, h0, r0;
    logic [AW-1:0] rows [4];
    seed = $urandom(32'h5EED);
    rstN = 0; reqValid = 0; reqWrite = 0; reqAddr = '0; reqWdata = '0;
    repeat (4) @(negedge clk);
    check(dramRasN && dramCasN && dramWeN && dramOeN, "R1", "strobes in reset",
          {dramRasN, dramCasN, dramWeN, dramOeN}, 4'hF);
    check(!rspValid, "R1", "rspValid in reset", rspValid, 0);
    rstN = 1;
    @(negedge clk);
    check(reqReady && !rspValid && dramRasN && dramCasN, "R1", "state after reset",
          {reqReady, rspValid, dramRasN, dramCasN}, 4'b1011);

    // Directed corners: extreme addresses, unwritten word.
    doOp(1, {14'h3FFF, 14'h3FFF}, 16'hBEEF);
    doOp(0, {14'h3FFF, 14'h3FFF}, '0);
    doOp(0, {14'h0000, 14'h0000}, '0);

    // Page hit right after a refresh, then a page miss.
    r0 = refCount;
    while (refCount == r0) @(negedge clk);
    a0 = actCount; h0 = hitCount;
    doOp(0, {14'h0123, 14'h0001}, '0);
    doOp(1, {14'h0123, 14'h0002}, 16'h1234);
    doOp(0, {14'h0123, 14'h0002}, '0);
    check(hitCount - h0 == 2, "R8", "page hits on open row", hitCount - h0, 2);
    check(actCount - a0 == 1, "R8", "single row activation", actCount - a0, 1);
    a0 = actCount; h0 = hitCount;
    doOp(0, {14'h0124, 14'h0002}, '0);
    check(actCount - a0 == 1 && hitCount == h0, "R9", "miss reopens row",
          actCount - a0, 1);

    // Random mixed traffic over a few rows, crossing many refreshes.
    rows[0] = 14'h0005; rows[1] = 14'h0006; rows[2] = 14'h3FFF; rows[3] = 14'h2A5A;
    for (int i = 0; i < 500; i++) begin
      logic [AW-1:0] rr, cc;
      rr = rows[$urandom % 4];
      cc = AW'($urandom % 8);
      if ($urandom % 2) doOp(1, {rr, cc}, DW'($urandom));
      else doOp(0, {rr, cc}, '0);
    end

    check(refCount >= cyc / REF_INTERVAL - 2, "R10", "refresh count",
          refCount, cyc / REF_INTERVAL - 2);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule